// File: doc/BRIEF.md
# Instruction byte splitter

This block sits between an instruction memory read port and the decode stage of a small 32-bit register machine. Bytes arrive one at a time over a valid/ready handshake. The block cuts the stream into instructions of one to six bytes and presents one decoded record per instruction. A record carries these fields:

- the instruction class and its sub-operation;
- the two register identifiers;
- a 32-bit constant;
- the length in bytes;
- the address of the instruction and the address of the one after it.

The first byte alone fixes how many more bytes belong to the instruction. Those further bytes are an optional register byte, then an optional constant of four bytes with the least significant byte first. A first byte with an unknown class or a sub-operation the class does not allow gives a one-byte record with its error flag set. Splitting then resumes at the following byte.

A record stays on the outputs until the consumer takes it. While a record waits, the block accepts no more bytes, so no byte is lost or reordered. Addresses start from a parameter value after reset and advance by the length of each record.

Top module: `insn_byte_splitter`

## Requirements
- R1: Reset behaviour. While reset is held, and after reset is released and has passed through two synchronising flops, the block accepts no byte until it is ready. Once ready, `out_valid` is 0 and `in_ready` is 1. The first record reports `out_pc` equal to START_ADDR (default 0).
- R2: The first byte of an instruction gives the class in bits 7:4 (`out_icode`) and the sub-operation in bits 3:0 (`out_ifun`).
- R3: The class fixes the length, reported on `out_len`:
  - 1 byte for classes 0x0, 0x1 and 0x9;
  - 2 bytes for classes 0x2, 0x6, 0xA and 0xB;
  - 5 bytes for classes 0x7 and 0x8;
  - 6 bytes for classes 0x3, 0x4 and 0x5.
- R4: Register byte. Classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry it as their second byte. Bits 7:4 of that byte go to `out_ra` and bits 3:0 go to `out_rb`. All other records, error records included, report 0x8 ("no register") on both fields.
- R5: Constant. Classes 0x7 and 0x8 carry four constant bytes right after the first byte. Classes 0x3, 0x4 and 0x5 carry them right after the register byte. The earliest of the four bytes is the least significant one on `out_const`. Records without a constant report 0.
- R6: A class above 0xB gives a record with `out_err` = 1, `out_len` = 1 and both register fields 0x8. The next byte starts a new instruction.
- R7: A sub-operation outside its class's allowed set also gives an error record as in R6. The allowed sets are:
  - 0 to 3 for class 0x6;
  - 0 to 6 for class 0x7;
  - only 0 for every other valid class.
- R8: `out_next_pc` equals `out_pc` plus `out_len`. Each record's `out_pc` equals the previous record's `out_next_pc`.
- R9: While `out_valid` is 1 and `out_ready` is 0, the record on the outputs does not change and `in_ready` is 0. In every other cycle after reset, `in_ready` is 1.
- R10: `out_valid` rises in the cycle after the clock edge that accepts an instruction's final byte. It falls after the edge where `out_ready` is 1, unless that same edge completes another instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Next byte of the instruction stream |
| in_ready | output | 1 | Block accepts the offered byte |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_icode | output | 4 | Instruction class |
| out_ifun | output | 4 | Sub-operation code |
| out_ra | output | 4 | First register identifier (0x8 = none) |
| out_rb | output | 4 | Second register identifier (0x8 = none) |
| out_const | output | 32 | Assembled constant |
| out_len | output | 3 | Instruction length in bytes |
| out_err | output | 1 | Invalid class or sub-operation |
| out_pc | output | ADDR_W | Address of this instruction |
| out_next_pc | output | ADDR_W | Address of the following instruction |

## Verification
The bench goes after every valid class with each of its legal sub-operations. It also drives the edges of the legal sets: ALU code 4, jump code 7, and a nonzero code on classes that allow only zero. A design with an off-by-one limit would pass one of these through, or flag a legal one. Unknown classes are placed directly ahead of valid multi-byte instructions, so a design that swallowed extra bytes after an error would shift every later record and break both the field and the address checks.

Constants with distinct bytes in every lane catch a reversed byte order. A design that overwrote a held record would fail the per-cycle comparison in the second half of the run, where gaps on `in_valid` and stalls on `out_ready` are interleaved. So would a design that kept taking bytes during a stall, or that delayed or repeated `out_valid`.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned NIB_W       = 4;
  localparam int unsigned CONST_BYTES = 4;
  localparam int unsigned CONST_W     = CONST_BYTES * BYTE_W;
  localparam int unsigned LEN_W       = 3;

  localparam logic [NIB_W-1:0] REG_NONE    = 4'h8;
  localparam logic [NIB_W-1:0] ALU_FUN_MAX = 4'd3;
  localparam logic [NIB_W-1:0] JMP_FUN_MAX = 4'd6;

  typedef enum logic [NIB_W-1:0] {
    CL_IDLE   = 4'h0,
    CL_STOP   = 4'h1,
    CL_RRMOVE = 4'h2,
    CL_IRMOVE = 4'h3,
    CL_RMMOVE = 4'h4,
    CL_MRMOVE = 4'h5,
    CL_ALU    = 4'h6,
    CL_JUMP   = 4'h7,
    CL_CALL   = 4'h8,
    CL_RET    = 4'h9,
    CL_PUSH   = 4'hA,
    CL_POP    = 4'hB
  } cls_e;

  typedef struct packed {
    logic [NIB_W-1:0]   icode;
    logic [NIB_W-1:0]   ifun;
    logic [NIB_W-1:0]   ra;
    logic [NIB_W-1:0]   rb;
    logic [CONST_W-1:0] k;
    logic [LEN_W-1:0]   len;
    logic               err;
  } rec_t;

endpackage

// File: rtl/ibs_head_class.sv
module ibs_head_class
  import ibs_pkg::*;
(
  input  logic [BYTE_W-1:0] head,
  output logic [LEN_W-1:0]  len,
  output logic              has_reg,
  output logic              bad
);

  logic [NIB_W-1:0] cls;
  logic [NIB_W-1:0] fun;
  logic             known;
  logic             fun_ok;
  logic [LEN_W-1:0] raw_len;
  logic             raw_reg;

  assign cls = head[BYTE_W-1:NIB_W];
  assign fun = head[NIB_W-1:0];

  always_comb begin
    known   = 1'b1;
    fun_ok  = (fun == '0);
    raw_len = 3'd1;
    raw_reg = 1'b0;
    case (cls)
      CL_IDLE, CL_STOP, CL_RET: begin
        raw_len = 3'd1;
      end
      CL_RRMOVE, CL_PUSH, CL_POP: begin
        raw_len = 3'd2;
        raw_reg = 1'b1;
      end
      CL_ALU: begin
        raw_len = 3'd2;
        raw_reg = 1'b1;
        fun_ok  = (fun <= ALU_FUN_MAX);
      end
      CL_JUMP: begin
        raw_len = 3'd5;
        fun_ok  = (fun <= JMP_FUN_MAX);
      end
      CL_CALL: begin
        raw_len = 3'd5;
      end
      CL_IRMOVE, CL_RMMOVE, CL_MRMOVE: begin
        raw_len = 3'd6;
        raw_reg = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end

  assign bad     = ~known | ~fun_ok;
  assign len     = bad ? 3'd1 : raw_len;
  assign has_reg = raw_reg & ~bad;

endmodule

// File: rtl/ibs_gather.sv
module ibs_gather
  import ibs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  input  logic [LEN_W-1:0]  cls_len,
  input  logic              cls_has_reg,
  input  logic              cls_bad,
  output logic              last,
  output rec_t              rec_nxt
);

  logic [LEN_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  hdr_q, hdr_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic               hreg_q, hreg_n;
  logic [NIB_W-1:0]   ra_q, ra_n, rb_q, rb_n;
  logic [CONST_W-1:0] k_q, k_n;
  logic               is_head;
  logic               reg_byte;
  logic [LEN_W-1:0]   cur_len;

  always_comb begin
    is_head  = (cnt_q == '0);
    cur_len  = is_head ? cls_len : len_q;
    reg_byte = ~is_head & hreg_q & (cnt_q == 3'd1);
    last     = take & ((cnt_q + 3'd1) == cur_len);

    hdr_n  = is_head ? din : hdr_q;
    len_n  = cur_len;
    hreg_n = is_head ? cls_has_reg : hreg_q;

    if (is_head) begin
      ra_n = REG_NONE;
      rb_n = REG_NONE;
      k_n  = '0;
    end else if (reg_byte) begin
      ra_n = din[BYTE_W-1:NIB_W];
      rb_n = din[NIB_W-1:0];
      k_n  = k_q;
    end else begin
      ra_n = ra_q;
      rb_n = rb_q;
      k_n  = {din, k_q[CONST_W-1:BYTE_W]};
    end

    cnt_n = last ? '0 : cnt_q + 3'd1;

    rec_nxt.icode = hdr_n[BYTE_W-1:NIB_W];
    rec_nxt.ifun  = hdr_n[NIB_W-1:0];
    rec_nxt.ra    = ra_n;
    rec_nxt.rb    = rb_n;
    rec_nxt.k     = k_n;
    rec_nxt.len   = cur_len;
    rec_nxt.err   = is_head & cls_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      len_q  <= '0;
      hreg_q <= 1'b0;
      ra_q   <= '0;
      rb_q   <= '0;
      k_q    <= '0;
    end else if (take) begin
      cnt_q  <= cnt_n;
      hdr_q  <= hdr_n;
      len_q  <= len_n;
      hreg_q <= hreg_n;
      ra_q   <= ra_n;
      rb_q   <= rb_n;
      k_q    <= k_n;
    end
  end

endmodule

// File: rtl/ibs_emit.sv
module ibs_emit
  import ibs_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  rec_t              rec_in,
  input  logic              out_ready,
  output logic              out_valid,
  output rec_t              rec_out,
  output logic [ADDR_W-1:0] cur_pc,
  output logic [ADDR_W-1:0] nxt_pc
);

  logic              vld_q, vld_n;
  rec_t              rec_q;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [ADDR_W-1:0] cur_q, nxt_q;

  always_comb begin
    pc_n  = pc_q + ADDR_W'(rec_in.len);
    vld_n = vld_q;
    if (last) begin
      vld_n = 1'b1;
    end else if (out_ready) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rec_q <= '0;
      pc_q  <= START_ADDR;
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      vld_q <= vld_n;
      if (last) begin
        rec_q <= rec_in;
        cur_q <= pc_q;
        nxt_q <= pc_n;
        pc_q  <= pc_n;
      end
    end
  end

  assign out_valid = vld_q;
  assign rec_out   = rec_q;
  assign cur_pc    = cur_q;
  assign nxt_pc    = nxt_q;

endmodule

// File: rtl/insn_byte_splitter.sv
module insn_byte_splitter
  import ibs_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [3:0]         out_icode,
  output logic [3:0]         out_ifun,
  output logic [3:0]         out_ra,
  output logic [3:0]         out_rb,
  output logic [31:0]        out_const,
  output logic [2:0]         out_len,
  output logic               out_err,
  output logic [ADDR_W-1:0]  out_pc,
  output logic [ADDR_W-1:0]  out_next_pc
);

  logic             rs_q1, rs_q2;
  logic             rst_s_n;
  logic             take;
  logic             last;
  logic [LEN_W-1:0] cls_len;
  logic             cls_has_reg;
  logic             cls_bad;
  rec_t             rec_nxt;
  rec_t             rec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  assign rst_s_n  = rs_q2;
  assign in_ready = rst_s_n & (~out_valid | out_ready);
  assign take     = in_valid & in_ready;

  ibs_head_class u_head (
    .head    (in_byte),
    .len     (cls_len),
    .has_reg (cls_has_reg),
    .bad     (cls_bad)
  );

  ibs_gather u_gather (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .take        (take),
    .din         (in_byte),
    .cls_len     (cls_len),
    .cls_has_reg (cls_has_reg),
    .cls_bad     (cls_bad),
    .last        (last),
    .rec_nxt     (rec_nxt)
  );

  ibs_emit #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
  ) u_emit (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .last      (last),
    .rec_in    (rec_nxt),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_out   (rec_q),
    .cur_pc    (out_pc),
    .nxt_pc    (out_next_pc)
  );

  assign out_icode = rec_q.icode;
  assign out_ifun  = rec_q.ifun;
  assign out_ra    = rec_q.ra;
  assign out_rb    = rec_q.rb;
  assign out_const = rec_q.k;
  assign out_len   = rec_q.len;
  assign out_err   = rec_q.err;

endmodule

// File: rtl/ibs_checker.sv
module ibs_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_icode,
  input logic [3:0]        out_ra,
  input logic [3:0]        out_rb,
  input logic [31:0]       out_const,
  input logic [2:0]        out_len,
  input logic              out_err,
  input logic [ADDR_W-1:0] out_pc,
  input logic [ADDR_W-1:0] out_next_pc
);

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len inside {3'd1, 3'd2, 3'd5, 3'd6})); // R3

  AST_NO_REG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_len == 3'd1 || out_len == 3'd5)) |-> (out_ra == 4'h8 && out_rb == 4'h8)); // R4

  AST_NO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len <= 3'd2) |-> (out_const == 32'h0)); // R5

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_len == 3'd1)); // R6

  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_icode > 4'hB) |-> out_err); // R6

  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_next_pc == out_pc + ADDR_W'(out_len))); // R8

  AST_ADDR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_pc == $past(out_next_pc))); // R8

  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_icode) && $stable(out_const)
                                   && $stable(out_pc) && $stable(out_len))); // R9

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

endmodule

bind insn_byte_splitter ibs_checker #(.ADDR_W(ADDR_W)) u_ibs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_icode   (out_icode),
  .out_ra      (out_ra),
  .out_rb      (out_rb),
  .out_const   (out_const),
  .out_len     (out_len),
  .out_err     (out_err),
  .out_pc      (out_pc),
  .out_next_pc (out_next_pc)
);

// File: tb/test_insn_byte_splitter.sv
module test_insn_byte_splitter;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          in_ready;
  logic          out_valid;
  logic          out_ready;
  logic [3:0]    out_icode, out_ifun, out_ra, out_rb;
  logic [31:0]   out_const;
  logic [2:0]    out_len;
  logic          out_err;
  logic [AW-1:0] out_pc, out_next_pc;

  always #10 clk = ~clk;

  insn_byte_splitter #(.ADDR_W(AW)) i_insn_byte_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_icode(out_icode), .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb),
    .out_const(out_const), .out_len(out_len), .out_err(out_err),
    .out_pc(out_pc), .out_next_pc(out_next_pc)
  );

  typedef struct {
    logic [3:0]  icode;
    logic [3:0]  ifun;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] k;
    int          len;
    bit          err;
    logic [31:0] pc;
    logic [31:0] nxt;
  } exp_t;

  logic [7:0] bq[$];
  exp_t       pend[$];
  exp_t       vis;
  bit         exp_valid;
  int         bi, got, half, cyc, mpc;
  int         nchk, nfail;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic add_insn(input logic [7:0] h, input logic [7:0] rr, input logic [31:0] k);
    exp_t e;
    int   n;
    bit   ok;
    bit   hr;
    ok = 1'b1;
    hr = 1'b0;
    n  = 1;
    case (h[7:4])
      4'h0, 4'h1, 4'h9: begin n = 1; ok = (h[3:0] == 0); end
      4'h2, 4'hA, 4'hB: begin n = 2; hr = 1'b1; ok = (h[3:0] == 0); end
      4'h6:             begin n = 2; hr = 1'b1; ok = (h[3:0] < 4); end
      4'h7:             begin n = 5; ok = (h[3:0] < 7); end
      4'h8:             begin n = 5; ok = (h[3:0] == 0); end
      4'h3, 4'h4, 4'h5: begin n = 6; hr = 1'b1; ok = (h[3:0] == 0); end
      default:          ok = 1'b0;
    endcase
    if (!ok) begin
      n  = 1;
      hr = 1'b0;
    end
    e.icode = h[7:4];
    e.ifun  = h[3:0];
    e.err   = !ok;
    e.len   = n;
    e.ra    = hr ? rr[7:4] : 4'h8;
    e.rb    = hr ? rr[3:0] : 4'h8;
    e.k     = (n >= 5) ? k : 32'h0;
    e.pc    = mpc;
    e.nxt   = mpc + n;
    mpc     = mpc + n;
    bq.push_back(h);
    if (hr) bq.push_back(rr);
    if (n >= 5) for (int i = 0; i < 4; i++) bq.push_back(k[8*i +: 8]);
    pend.push_back(e);
  endtask

  task automatic build_set(input int salt);
    add_insn(8'h00, 8'h00, 0);
    add_insn(8'h10, 8'h00, 0);
    add_insn(8'h20, 8'h12 + salt[7:0], 0);
    add_insn(8'h30, 8'h83, 32'h12345678 ^ salt);
    add_insn(8'h40, 8'h45, 32'hDEADBEEF);
    add_insn(8'h50, 8'h67, 32'h00000100 + salt);
    for (int f = 0; f < 4; f++) add_insn(8'h60 | f[7:0], 8'h06 + 8'(f * 16), 0);
    for (int f = 0; f < 7; f++) add_insn(8'h70 | f[7:0], 8'h00, 32'hA1B2C3D0 + f);
    add_insn(8'h80, 8'h00, 32'hCAFEF00D);
    add_insn(8'h90, 8'h00, 0);
    add_insn(8'hA0, 8'h48, 0);
    add_insn(8'hB0, 8'h58, 0);
    add_insn(8'hC0, 8'h00, 0);
    add_insn(8'h30, 8'h81, 32'h0BADF00D);
    add_insn(8'hD5, 8'h00, 0);
    add_insn(8'hE1, 8'h00, 0);
    add_insn(8'h70, 8'h00, 32'h00C0FFEE);
    add_insn(8'hF0, 8'h00, 0);
    add_insn(8'h64, 8'h00, 0);
    add_insn(8'h77, 8'h00, 0);
    add_insn(8'h01, 8'h00, 0);
    add_insn(8'h35, 8'h00, 0);
    add_insn(8'h91, 8'h00, 0);
    add_insn(8'h63, 8'h9A, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0; bi = 0; got = 0; cyc = 0; mpc = 0;
    exp_valid = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    build_set(0);
    half = bq.size();
    build_set(3);

    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", in_ready, 1'b0);
    chk("R1", "out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 1'b0);
    chk("R1", "in_ready after reset", in_ready, 1'b1);
    chk("R1", "first pc", pend[0].pc, 32'h0);

    while (bi < bq.size() || pend.size() > 0 || exp_valid) begin
      chk("R10", "out_valid", out_valid, exp_valid);
      if (exp_valid && out_valid) begin
        chk("R2", "icode", out_icode, vis.icode);
        chk("R2", "ifun", out_ifun, vis.ifun);
        chk("R3", "len", out_len, vis.len);
        chk("R4", "ra", out_ra, vis.ra);
        chk("R4", "rb", out_rb, vis.rb);
        chk("R5", "const", out_const, vis.k);
        chk(vis.icode > 4'hB ? "R6" : "R7", "err", out_err, vis.err);
        chk("R8", "pc", out_pc, vis.pc);
        chk("R8", "next pc", out_next_pc, vis.nxt);
      end
      cyc++;
      if (bi < half) begin
        in_valid  = (bi < bq.size());
        out_ready = 1'b1;
      end else begin
        in_valid  = (bi < bq.size()) && (cyc % 3 != 0);
        out_ready = (cyc % 4 != 1) && (cyc % 7 != 2);
      end
      in_byte = (bi < bq.size()) ? bq[bi] : 8'h00;
      #1;
      chk("R9", "in_ready", in_ready, !(out_valid && !out_ready));
      if (out_valid && out_ready) exp_valid = 1'b0;
      if (in_valid && in_ready) begin
        bi++;
        got++;
        if (got == pend[0].len) begin
          vis       = pend.pop_front();
          exp_valid = 1'b1;
          got       = 0;
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "idle out_valid", out_valid, 1'b0);
    summary();
    $finish;
  end

endmodule